// File: doc/BRIEF.md
# String Transfer Sequencer

This unit carries out one string instruction at a time: load, store or move. Each element is a byte, a word or a doubleword. On `start` it captures a source pointer, a destination pointer, a repeat count and an accumulator. It then drives a single memory port. Every access on that port carries a tag that selects either the data segment or the extra segment. After each element the pointers step by the element width. A direction input chooses whether they step upward or downward. Both pointers wrap modulo 2^16.

With repeat enabled, the count falls by one per element and the operation runs until the count reaches zero. If the count is already zero at start, nothing is transferred. Repeat is not allowed on a load, and such a request is rejected without any access. A move spends a read cycle and then a write cycle on each element. The memory's `mem_ready` input can stall any cycle of any operation.

Top module: `str_xfer_engine`

## Requirements
- R1: The element size code `elem_size` selects 0 = byte, 1 = word, 2 = doubleword, with 3 treated as doubleword. Each pointer that an element uses changes by 1, 2 or 4 respectively.
- R2: `dir_dn` = 0 makes the pointers step upward and `dir_dn` = 1 makes them step downward, both modulo 65536.
- R3: Load (`op` = 0) reads at `mem_seg` = 0 (data segment) from the source pointer. Only the low 1, 2 or 4 accumulator bytes are replaced by the read data, and the upper bytes are kept. The destination pointer is unchanged.
- R4: Store (`op` = 1) writes at `mem_seg` = 1 (extra segment) to the destination pointer. `mem_wdata` carries the low accumulator bytes of the element size, with the bytes above them zero. The source pointer is unchanged.
- R5: Move (`op` = 2, with 3 treated as move) reads an element from segment 0 at the source pointer. It then writes the same masked data to segment 1 at the destination pointer, and both pointers advance. A write always uses segment 1.
- R6: With `rep_en` = 0, exactly one element is transferred and `cnt` keeps its start value.
- R7: With `rep_en` = 1 and a start count N > 0, exactly N elements are transferred and `cnt` falls by one per element, ending at 0.
- R8: With `rep_en` = 1 and a start count of 0, no access is made and `done` pulses in the cycle after start, with `busy` staying low.
- R9: A load with `rep_en` = 1 is rejected. No access is made, `done` and `rejected` pulse together in the cycle after start, and the pointers, count and accumulator equal their start values.
- R10: While `mem_ready` is low, a request holds its address, direction, segment and write data unchanged in the next cycle.
- R11: `busy` is high from the cycle after start until the final access completes. `done` is a one-cycle pulse in the cycle after that access. A `start` raised while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (sampled only when idle) |
| op | input | 2 | 0 load, 1 store, 2/3 move |
| elem_size | input | 2 | 0 byte, 1 word, 2/3 doubleword |
| rep_en | input | 1 | Repeat under the count |
| dir_dn | input | 1 | 1 steps pointers downward |
| src_init | input | 16 | Starting source pointer |
| dst_init | input | 16 | Starting destination pointer |
| cnt_init | input | 16 | Starting repeat count |
| acc_init | input | 32 | Starting accumulator |
| mem_req | output | 1 | Memory access valid |
| mem_we | output | 1 | 1 write, 0 read |
| mem_seg | output | 1 | 0 data segment, 1 extra segment |
| mem_addr | output | 16 | Access offset |
| mem_size | output | 2 | Element size code of the access |
| mem_wdata | output | 32 | Write data, zero above the element |
| mem_rdata | input | 32 | Read data |
| mem_ready | input | 1 | Access completes at this edge |
| src_ptr | output | 16 | Current/final source pointer |
| dst_ptr | output | 16 | Current/final destination pointer |
| cnt | output | 16 | Current/final count |
| acc | output | 32 | Current/final accumulator |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rejected | output | 1 | Pulses with done on a refused repeated load |

## Verification
Some properties are checked on every cycle:
- a stalled request holds steady;
- writes are tagged for the extra segment and reads for the data segment;
- `done` lasts one cycle and `rejected` only comes with it;
- the count drops by exactly one per element without passing zero;
- the element size stays fixed for a whole operation.

Other behaviour only the scenarios can show, because it needs a model of the whole run:
- the exact number of elements for a given count;
- the order of addresses under both directions and across the wrap;
- the merged accumulator bytes;
- that a start during an operation leaves the access sequence untouched;
- the final pointer and count values.

// File: rtl/str_pkg.sv
// Shared types and helpers for the string transfer sequencer.
// Assumes a 32-bit data path and byte lanes of 8 bits.
package str_pkg;
    localparam int DATA_W = 32;

    localparam logic [1:0] OP_LOAD  = 2'd0;
    localparam logic [1:0] OP_STORE = 2'd1;

    localparam logic SEG_DATA  = 1'b0;
    localparam logic SEG_EXTRA = 1'b1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } str_state_e;

    // Size code to shift amount: 3 is folded onto doubleword.
    function automatic logic [1:0] size_shift(input logic [1:0] sz);
        return (sz == 2'd3) ? 2'd2 : sz;
    endfunction
endpackage

// File: rtl/str_ptr_adv.sv
// Next-pointer computation: steps a pointer by the element width,
// up or down, wrapping at the pointer width. Purely combinational.
module str_ptr_adv
    import str_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] ptr,
    input  logic [1:0]        sz,
    input  logic              dn,
    output logic [ADDR_W-1:0] nxt
);
    logic [ADDR_W-1:0] step;

    // Step of 1, 2 or 4 and the wrapped sum or difference.
    always_comb begin
        step = ADDR_W'(1) << size_shift(sz);
        nxt  = dn ? (ptr - step) : (ptr + step);
    end
endmodule

// File: rtl/str_lane_merge.sv
// Byte-lane merge: the low 1, 2 or 4 lanes come from new_v, the rest
// from old_v. With old_v tied to zero it acts as a size mask.
module str_lane_merge
    import str_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] old_v,
    input  logic [W-1:0] new_v,
    input  logic [1:0]   sz,
    output logic [W-1:0] out_v
);
    localparam int LANES = W / 8;

    logic [7:0] nbytes;

    // Number of lanes the element occupies.
    always_comb nbytes = 8'(1) << size_shift(sz);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign out_v[g*8 +: 8] = (8'(g) < nbytes) ? new_v[g*8 +: 8] : old_v[g*8 +: 8];
    end
endmodule

// File: rtl/str_rep_count.sv
// Repeat counter: loads at start, decrements once per finished element.
// Assumes the controller never decrements a zero count.
module str_rep_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] value,
    output logic             last
);
    // Count register with load priority over decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)    value <= '0;
        else if (load) value <= load_val;
        else if (dec)  value <= value - CNT_W'(1);
    end

    // Final element is reached when the count reads one.
    always_comb last = (value == CNT_W'(1));

    // R7: one element lowers the count by exactly one
    p_cnt_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load) |=> (value == $past(value) - CNT_W'(1)));

    // R7: no decrement below zero
    p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (value != '0));
endmodule

// File: rtl/str_xfer_engine.sv
// String transfer sequencer top. Runs load/store/move on byte, word or
// doubleword elements with pointer stepping, optional repeat count and a
// single ready-stalled memory port tagged by segment. Assumes one access
// per cycle and that mem_rdata is valid in the cycle mem_ready is high.
module str_xfer_engine
    import str_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        op,
    input  logic [1:0]        elem_size,
    input  logic              rep_en,
    input  logic              dir_dn,
    input  logic [ADDR_W-1:0] src_init,
    input  logic [ADDR_W-1:0] dst_init,
    input  logic [CNT_W-1:0]  cnt_init,
    input  logic [DATA_W-1:0] acc_init,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_seg,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_size,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] src_ptr,
    output logic [ADDR_W-1:0] dst_ptr,
    output logic [CNT_W-1:0]  cnt,
    output logic [DATA_W-1:0] acc,
    output logic              busy,
    output logic              done,
    output logic              rejected
);
    str_state_e        state;
    logic [ADDR_W-1:0] src_q, dst_q, src_nxt, dst_nxt;
    logic [DATA_W-1:0] acc_q, tmp_q, acc_merged, rd_masked, st_masked;
    logic [1:0]        op_q, sz_q;
    logic              rep_q, dir_q, done_q, rej_q;
    logic              is_load, is_store, elem_done, elem_last, cnt_load, cnt_last;

    // Operation decode and element bookkeeping.
    always_comb begin
        is_load   = (op_q == OP_LOAD);
        is_store  = (op_q == OP_STORE);
        elem_done = mem_ready && ((state == ST_WRITE) || (state == ST_READ && is_load));
        elem_last = !rep_q || cnt_last;
        cnt_load  = (state == ST_IDLE) && start;
    end

    str_ptr_adv #(.ADDR_W(ADDR_W)) u_src_adv (
        .ptr(src_q), .sz(sz_q), .dn(dir_q), .nxt(src_nxt));
    str_ptr_adv #(.ADDR_W(ADDR_W)) u_dst_adv (
        .ptr(dst_q), .sz(sz_q), .dn(dir_q), .nxt(dst_nxt));

    str_lane_merge #(.W(DATA_W)) u_acc_merge (
        .old_v(acc_q), .new_v(mem_rdata), .sz(sz_q), .out_v(acc_merged));
    str_lane_merge #(.W(DATA_W)) u_rd_mask (
        .old_v('0), .new_v(mem_rdata), .sz(sz_q), .out_v(rd_masked));
    str_lane_merge #(.W(DATA_W)) u_st_mask (
        .old_v('0), .new_v(acc_q), .sz(sz_q), .out_v(st_masked));

    str_rep_count #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_init),
        .dec(elem_done && rep_q), .value(cnt), .last(cnt_last));

    // Sequencer: capture on start, then read/write phases under ready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            src_q  <= '0;
            dst_q  <= '0;
            acc_q  <= '0;
            tmp_q  <= '0;
            op_q   <= OP_LOAD;
            sz_q   <= 2'd0;
            rep_q  <= 1'b0;
            dir_q  <= 1'b0;
            done_q <= 1'b0;
            rej_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            rej_q  <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    src_q <= src_init;
                    dst_q <= dst_init;
                    acc_q <= acc_init;
                    op_q  <= op;
                    sz_q  <= elem_size;
                    rep_q <= rep_en;
                    dir_q <= dir_dn;
                    if (rep_en && op == OP_LOAD) begin
                        done_q <= 1'b1;
                        rej_q  <= 1'b1;
                    end else if (rep_en && cnt_init == '0) begin
                        done_q <= 1'b1;
                    end else begin
                        state <= (op == OP_STORE) ? ST_WRITE : ST_READ;
                    end
                end
                ST_READ: if (mem_ready) begin
                    src_q <= src_nxt;
                    if (is_load) begin
                        acc_q  <= acc_merged;
                        state  <= ST_IDLE;
                        done_q <= 1'b1;
                    end else begin
                        tmp_q <= rd_masked;
                        state <= ST_WRITE;
                    end
                end
                ST_WRITE: if (mem_ready) begin
                    dst_q <= dst_nxt;
                    if (elem_last) begin
                        state  <= ST_IDLE;
                        done_q <= 1'b1;
                    end else begin
                        state <= is_store ? ST_WRITE : ST_READ;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Memory port and result outputs.
    always_comb begin
        mem_req   = (state != ST_IDLE);
        mem_we    = (state == ST_WRITE);
        mem_seg   = (state == ST_WRITE) ? SEG_EXTRA : SEG_DATA;
        mem_addr  = (state == ST_WRITE) ? dst_q : src_q;
        mem_size  = sz_q;
        mem_wdata = is_store ? st_masked : tmp_q;
        src_ptr   = src_q;
        dst_ptr   = dst_q;
        acc       = acc_q;
        busy      = (state != ST_IDLE);
        done      = done_q;
        rejected  = rej_q;
    end

    // R10: a stalled request keeps its attributes
    p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                     && $stable(mem_seg) && $stable(mem_wdata)));

    // R5: every write lands in the extra segment
    p_write_extra_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_seg == SEG_EXTRA));

    // R3: every read comes from the data segment
    p_read_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |-> (mem_seg == SEG_DATA));

    // R11: done is a single-cycle pulse
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: a rejection is reported only with done and no activity
    p_reject_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rejected |-> (done && !busy));

    // R11: element size cannot change while an operation runs
    p_size_fixed_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || $stable(mem_size)));

    // R1: a completed read moves the source pointer
    p_src_moves_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ready) |=> (src_ptr != $past(src_ptr)));
endmodule

// File: tb/test_str_xfer_engine.sv
`timescale 1ns/1ps
// Bench: behavioural model builds the expected access queue and final
// state per operation; compared against the port every clock.
module test_str_xfer_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = 2'd0, elem_size = 2'd0;
    logic        rep_en = 1'b0, dir_dn = 1'b0;
    logic [15:0] src_init = '0, dst_init = '0, cnt_init = '0;
    logic [31:0] acc_init = '0;
    logic        mem_req, mem_we, mem_seg, mem_ready = 1'b1;
    logic [15:0] mem_addr;
    logic [1:0]  mem_size;
    logic [31:0] mem_wdata, mem_rdata;
    logic [15:0] src_ptr, dst_ptr, cnt;
    logic [31:0] acc;
    logic        busy, done, rejected;

    int n_chk = 0, n_err = 0, cyc = 0;
    logic [15:0] lfsr = 16'hACE1;

    typedef struct {
        bit          we;
        bit          seg;
        logic [15:0] addr;
        logic [31:0] wdata;
    } acc_t;
    acc_t q[$];

    always #2 clk = ~clk;

    function automatic logic [31:0] rd_fn(input logic [15:0] a);
        return {a ^ 16'hA5C3, a ^ 16'h3C5A};
    endfunction
    assign mem_rdata = rd_fn(mem_addr);

    str_xfer_engine i_str_xfer_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .elem_size(elem_size),
        .rep_en(rep_en), .dir_dn(dir_dn), .src_init(src_init), .dst_init(dst_init),
        .cnt_init(cnt_init), .acc_init(acc_init), .mem_req(mem_req), .mem_we(mem_we),
        .mem_seg(mem_seg), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .src_ptr(src_ptr), .dst_ptr(dst_ptr), .cnt(cnt), .acc(acc),
        .busy(busy), .done(done), .rejected(rejected));

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mask_of(input logic [1:0] sz);
        return (sz == 2'd0) ? 32'h0000_00FF : (sz == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
    endfunction

    function automatic logic [15:0] nx(input logic [15:0] p, input logic [1:0] sz, input bit dn);
        int st;
        st = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        return dn ? 16'(p - 16'(st)) : 16'(p + 16'(st));
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired actual=%0d expected<100000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    task automatic run_op(input string tag, input logic [1:0] o, input logic [1:0] sz,
                          input bit rp, input bit dn, input logic [15:0] si,
                          input logic [15:0] di, input logic [15:0] cx,
                          input logic [31:0] a, input bit rnd, input bit poke);
        logic [15:0] e_si = si, e_di = di, e_cx = cx;
        logic [31:0] e_acc = a, m = mask_of(sz);
        bit e_rej = 0, pend, fin = 0;
        int n, steps = 0, taken = 0;
        acc_t r;
        q.delete();
        if (rp && o == 2'd0) begin e_rej = 1; n = 0; end
        else if (rp) n = int'(cx);
        else n = 1;
        for (int k = 0; k < n; k++) begin
            if (o == 2'd0) begin
                r.we = 0; r.seg = 0; r.addr = e_si; r.wdata = '0; q.push_back(r);
                e_acc = (e_acc & ~m) | (rd_fn(e_si) & m);
                e_si = nx(e_si, sz, dn);
            end else if (o == 2'd1) begin
                r.we = 1; r.seg = 1; r.addr = e_di; r.wdata = e_acc & m; q.push_back(r);
                e_di = nx(e_di, sz, dn);
            end else begin
                r.we = 0; r.seg = 0; r.addr = e_si; r.wdata = '0; q.push_back(r);
                r.we = 1; r.seg = 1; r.addr = e_di; r.wdata = rd_fn(e_si) & m; q.push_back(r);
                e_si = nx(e_si, sz, dn);
                e_di = nx(e_di, sz, dn);
            end
        end
        if (rp && !e_rej) e_cx = '0;

        @(negedge clk);
        op = o; elem_size = sz; rep_en = rp; dir_dn = dn;
        src_init = si; dst_init = di; cnt_init = cx; acc_init = a;
        start = 1'b1; mem_ready = 1'b1;
        @(negedge clk);
        start = 1'b0;
        pend = (q.size() == 0);
        while (!fin) begin
            chk("R11", {tag, " busy"}, 32'(busy), 32'(q.size() != 0));
            chk("R11", {tag, " done"}, 32'(done), 32'(pend));
            if (pend) begin
                chk("R9", {tag, " rejected"}, 32'(rejected), 32'(e_rej));
                fin = 1;
            end
            start = 1'b0;
            if (q.size() != 0) begin
                r = q[0];
                chk(tag, "mem_req", 32'(mem_req), 32'd1);
                chk(tag, "mem_we", 32'(mem_we), 32'(r.we));
                chk(tag, "mem_seg", 32'(mem_seg), 32'(r.seg));
                chk(tag, "mem_addr", 32'(mem_addr), 32'(r.addr));
                chk("R1", {tag, " mem_size"}, 32'(mem_size), 32'(sz));
                if (r.we) chk(tag, "mem_wdata", mem_wdata, r.wdata);
                // R11: a start while busy with other settings must be ignored
                if (poke && taken == 2) begin
                    start = 1'b1; op = 2'd2; src_init = 16'h0BAD; cnt_init = 16'd1;
                end
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                mem_ready = rnd ? lfsr[0] : 1'b1;
                if (mem_ready) begin
                    void'(q.pop_front());
                    taken++;
                    if (q.size() == 0) pend = 1;
                end
            end else if (!fin) begin
                chk(tag, "mem_req idle", 32'(mem_req), 32'd0);
            end
            steps++;
            if (steps > 5000) begin
                chk(tag, "timeout", 32'd0, 32'd1);
                fin = 1;
            end
            @(negedge clk);
        end
        start = 1'b0;
        mem_ready = 1'b1;
        chk("R1 R2", {tag, " src_ptr"}, 32'(src_ptr), 32'(e_si));
        chk("R1 R2", {tag, " dst_ptr"}, 32'(dst_ptr), 32'(e_di));
        chk("R6 R7", {tag, " cnt"}, 32'(cnt), 32'(e_cx));
        chk("R3", {tag, " acc"}, acc, e_acc);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk("R11", "reset busy", 32'(busy), 32'd0);
        chk("R11", "reset done", 32'(done), 32'd0);
        chk("R11", "reset mem_req", 32'(mem_req), 32'd0);
        chk("R11", "reset src_ptr", 32'(src_ptr), 32'd0);
        // R3 R1 R6: single byte load upward
        run_op("R3", 2'd0, 2'd0, 0, 0, 16'h1000, 16'h2000, 16'd7, 32'hDEADBEEF, 0, 0);
        // R2: word load downward across zero with stalls
        run_op("R2", 2'd0, 2'd1, 0, 1, 16'h0000, 16'h4000, 16'd3, 32'h1122_3344, 1, 0);
        // R2: doubleword load upward across the top
        run_op("R2", 2'd0, 2'd2, 0, 0, 16'hFFFE, 16'h0000, 16'd0, 32'h0, 0, 0);
        // R4: single word store
        run_op("R4", 2'd1, 2'd1, 0, 0, 16'h0300, 16'h8000, 16'd2, 32'hCAFE_F00D, 0, 0);
        // R7: repeated byte store, count 100, stalls
        run_op("R7", 2'd1, 2'd0, 1, 0, 16'h0000, 16'h0100, 16'd100, 32'h0000_00A5, 1, 0);
        // R5 R10: repeated byte move with stalls
        run_op("R5", 2'd2, 2'd0, 1, 0, 16'h0040, 16'h0900, 16'd5, 32'h0, 1, 0);
        // R2 R5: repeated doubleword move downward wrapping the source
        run_op("R5", 2'd2, 2'd2, 1, 1, 16'h0002, 16'h0010, 16'd3, 32'h0, 0, 0);
        // R1: size code 3 behaves as doubleword, op 3 as move
        run_op("R1", 2'd3, 2'd3, 0, 0, 16'h0020, 16'h0030, 16'd4, 32'h0, 0, 0);
        // R8: repeat with zero count
        run_op("R8", 2'd1, 2'd2, 1, 0, 16'h0500, 16'h0600, 16'd0, 32'h5555_AAAA, 0, 0);
        // R9: repeated load refused
        run_op("R9", 2'd0, 2'd1, 1, 0, 16'h0700, 16'h0800, 16'd4, 32'h0BAD_CAFE, 0, 0);
        // R11: start while busy ignored, repeated word store downward
        run_op("R11", 2'd1, 2'd1, 1, 1, 16'h0001, 16'h0004, 16'd6, 32'h7777_1234, 1, 1);
        // R6: single word move downward, count untouched
        run_op("R6", 2'd2, 2'd1, 0, 1, 16'hA000, 16'hB000, 16'd9, 32'h0, 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule